// File: doc/BRIEF.md
# Priority-Resolved Pad Function Selector

This block decides which function drives each pad of a bank of general-purpose pins. It holds five select registers, one per peripheral function, and a pull-select register. All of them are reached through a simple single-cycle register bus. In every select register, bit N refers to pin N.

More than one select bit may be set for the same pin at the same time. A fixed priority picks the winner. A pin with no select bit set falls back to the GPIO core. The winning function's output value and output enable go to the pad. Once a pin belongs to a peripheral, the GPIO core's drive has no effect on that pad, and no extra write is needed to stop it.

The resolved 3-bit function code of every pin is exported so that status logic can read it. A system integrator wires the GPIO core and the five peripheral output ports to the block and routes its pad outputs to the I/O ring.

Top module: `pin_func_sel`

## Requirements
- R1: After the active-low reset, all six registers are zero, every pin reports function code 0, and `rsp_rdata_o` is zero.
- R2: A write (`req_valid_i`=1, `req_write_i`=1) updates the addressed register at the clock edge. The byte offsets are 0x14 (function 1), 0x8C (function 2), 0x94 (function 3), 0x9C (function 4), 0xA4 (function 5) and 0xAC (pull select). A read (`req_valid_i`=1, `req_write_i`=0) presents that register on `rsp_rdata_o` in the next cycle. In every cycle that follows a non-read, `rsp_rdata_o` is 0.
- R3: A read of any other offset returns 0. A write to any other offset leaves all six registers unchanged.
- R4: When one or more select bits are set for a pin, its code is the number of the highest-priority set function. Priority order is 1 (offset 0x14), 2, 3, 4, 5 (offset 0xA4). Lower-priority bits are ignored.
- R5: A pin with no select bit set in any of the five registers has code 0 (GPIO).
- R6: The code of pin p appears on `func_code_o[3p+2:3p]`. It changes in the same cycle the register write takes effect.
- R7: For a pin with code 0, `pad_out_o[p]` and `pad_oe_o[p]` equal `gpio_out_i[p]` and `gpio_oe_i[p]`.
- R8: For a pin with code f (1 to 5), `pad_out_o[p]` and `pad_oe_o[p]` equal `periph_out_i[(f-1)*32+p]` and `periph_oe_i[(f-1)*32+p]`. The GPIO inputs have no effect on that pin.
- R9: `pull_sel_o` always shows the contents of the pull-select register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Bus request strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Byte offset |
| req_wdata_i | input | 32 | Write data |
| rsp_rdata_o | output | 32 | Read data, one cycle after the request |
| gpio_out_i | input | 32 | GPIO core output values |
| gpio_oe_i | input | 32 | GPIO core output enables |
| periph_out_i | input | 160 | Peripheral output values, function f at bits [(f-1)*32 +: 32] |
| periph_oe_i | input | 160 | Peripheral output enables, same layout |
| pad_out_o | output | 32 | Pad output values |
| pad_oe_o | output | 32 | Pad output enables |
| pull_sel_o | output | 32 | Pull-select register contents |
| func_code_o | output | 96 | Resolved 3-bit function code per pin |

## Verification
Directed patterns come first. A single function is set on a pin, then all five functions are set on the same pins and removed one by one from the top of the priority order, so that each step exposes the next winner. This separates a correct priority chain from a reversed or partly missing one. Reads of defined and undefined offsets, and writes to undefined offsets, show whether address decode aliases any register. A long random phase then writes random select patterns while the GPIO and peripheral inputs change every cycle. A reference model is compared in every cycle, which catches a pad taking its value from the wrong source, in particular GPIO leaking through on a pin that a peripheral owns.

// File: rtl/pin_func_pkg.sv
package pin_func_pkg;
  localparam int NUM_FUNCS = 5;
  localparam int FUNC_W    = 3;
  localparam int ADDR_W    = 8;

  typedef enum logic [FUNC_W-1:0] {
    FN_GPIO = 3'd0,
    FN_F1   = 3'd1,
    FN_F2   = 3'd2,
    FN_F3   = 3'd3,
    FN_F4   = 3'd4,
    FN_F5   = 3'd5
  } func_e;

  // select register offsets, index = priority (0 highest)
  localparam logic [ADDR_W-1:0] SEL_ADDR [NUM_FUNCS] = '{8'h14, 8'h8C, 8'h94, 8'h9C, 8'hA4};
  localparam logic [ADDR_W-1:0] PULL_ADDR = 8'hAC;
endpackage

// File: rtl/pfs_regs.sv
module pfs_regs
  import pin_func_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               req_valid_i,
  input  logic                               req_write_i,
  input  logic [ADDR_W-1:0]                  req_addr_i,
  input  logic [NUM_PINS-1:0]                req_wdata_i,
  output logic [NUM_PINS-1:0]                rsp_rdata_o,
  output logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_o,
  output logic [NUM_PINS-1:0]                pull_o
);
  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_q;
  logic [NUM_PINS-1:0]                pull_q;
  logic [NUM_PINS-1:0]                rdata_q;
  logic [NUM_PINS-1:0]                rd_mux;
  logic [NUM_FUNCS-1:0]               hit_sel;
  logic                               hit_pull;
  logic                               hit_any;
  logic                               wr_en;
  logic                               rd_en;

  assign wr_en    = req_valid_i && req_write_i;
  assign rd_en    = req_valid_i && !req_write_i;
  assign hit_pull = (req_addr_i == PULL_ADDR);

  for (genvar k = 0; k < NUM_FUNCS; k++) begin : g_dec
    assign hit_sel[k] = (req_addr_i == SEL_ADDR[k]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                 sel_q[k] <= '0;
      else if (wr_en && hit_sel[k]) sel_q[k] <= req_wdata_i;
    end
  end

  assign hit_any = |hit_sel || hit_pull;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pull_q <= '0;
    else if (wr_en && hit_pull) pull_q <= req_wdata_i;
  end

  always_comb begin
    rd_mux = '0;
    for (int k = 0; k < NUM_FUNCS; k++)
      if (hit_sel[k]) rd_mux = sel_q[k];
    if (hit_pull) rd_mux = pull_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_mux : '0;
  end

  assign rsp_rdata_o = rdata_q;
  assign sel_o       = sel_q;
  assign pull_o      = pull_q;

  AST_RDATA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en |=> rsp_rdata_o == '0); // R2
  AST_UNDEF_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en && !hit_any) |=> rsp_rdata_o == '0); // R3
  AST_UNDEF_WRITE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en && !hit_any) |=> ($stable(sel_q) && $stable(pull_q))); // R3
endmodule

// File: rtl/pfs_resolve.sv
module pfs_resolve
  import pin_func_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel_i,
  output logic [NUM_PINS*FUNC_W-1:0]         code_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_FUNCS-1:0] bits;
    func_e                code;

    for (genvar k = 0; k < NUM_FUNCS; k++) begin : g_col
      assign bits[k] = sel_i[k][p];
    end

    always_comb begin
      if      (bits[0]) code = FN_F1;
      else if (bits[1]) code = FN_F2;
      else if (bits[2]) code = FN_F3;
      else if (bits[3]) code = FN_F4;
      else if (bits[4]) code = FN_F5;
      else              code = FN_GPIO;
    end

    assign code_o[p*FUNC_W +: FUNC_W] = code;

    AST_GPIO_FALLBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bits == '0) |-> code_o[p*FUNC_W +: FUNC_W] == 3'd0); // R5
    AST_TOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bits[0] |-> code_o[p*FUNC_W +: FUNC_W] == 3'd1); // R4
    AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      code_o[p*FUNC_W +: FUNC_W] <= 3'd5); // R4
  end
endmodule

// File: rtl/pfs_padmux.sv
module pfs_padmux
  import pin_func_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic [NUM_PINS*FUNC_W-1:0]    code_i,
  input  logic [NUM_PINS-1:0]           gpio_out_i,
  input  logic [NUM_PINS-1:0]           gpio_oe_i,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_out_i,
  input  logic [NUM_FUNCS*NUM_PINS-1:0] periph_oe_i,
  output logic [NUM_PINS-1:0]           pad_out_o,
  output logic [NUM_PINS-1:0]           pad_oe_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [NUM_FUNCS-1:0] f_out, f_oe;
    logic [FUNC_W-1:0]    code;

    assign code = code_i[p*FUNC_W +: FUNC_W];

    for (genvar k = 0; k < NUM_FUNCS; k++) begin : g_src
      assign f_out[k] = periph_out_i[k*NUM_PINS + p];
      assign f_oe[k]  = periph_oe_i[k*NUM_PINS + p];
    end

    // GPIO drive is dropped as soon as any peripheral owns the pin
    always_comb begin
      pad_out_o[p] = 1'b0;
      pad_oe_o[p]  = 1'b0;
      if (code == FN_GPIO) begin
        pad_out_o[p] = gpio_out_i[p];
        pad_oe_o[p]  = gpio_oe_i[p];
      end else begin
        for (int k = 0; k < NUM_FUNCS; k++)
          if (code == FUNC_W'(k + 1)) begin
            pad_out_o[p] = f_out[k];
            pad_oe_o[p]  = f_oe[k];
          end
      end
    end
  end
endmodule

// File: rtl/pin_func_sel.sv
module pin_func_sel
  import pin_func_pkg::*;
#(
  parameter int NUM_PINS = 32
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  input  logic                          req_write_i,
  input  logic [7:0]                    req_addr_i,
  input  logic [NUM_PINS-1:0]           req_wdata_i,
  output logic [NUM_PINS-1:0]           rsp_rdata_o,
  input  logic [NUM_PINS-1:0]           gpio_out_i,
  input  logic [NUM_PINS-1:0]           gpio_oe_i,
  input  logic [5*NUM_PINS-1:0]         periph_out_i,
  input  logic [5*NUM_PINS-1:0]         periph_oe_i,
  output logic [NUM_PINS-1:0]           pad_out_o,
  output logic [NUM_PINS-1:0]           pad_oe_o,
  output logic [NUM_PINS-1:0]           pull_sel_o,
  output logic [3*NUM_PINS-1:0]         func_code_o
);
  logic [NUM_FUNCS-1:0][NUM_PINS-1:0] sel;
  logic [NUM_PINS*FUNC_W-1:0]         code;

  pfs_regs #(.NUM_PINS(NUM_PINS)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_write_i (req_write_i),
    .req_addr_i  (req_addr_i),
    .req_wdata_i (req_wdata_i),
    .rsp_rdata_o (rsp_rdata_o),
    .sel_o       (sel),
    .pull_o      (pull_sel_o)
  );

  pfs_resolve #(.NUM_PINS(NUM_PINS)) u_resolve (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sel_i  (sel),
    .code_o (code)
  );

  pfs_padmux #(.NUM_PINS(NUM_PINS)) u_padmux (
    .code_i       (code),
    .gpio_out_i   (gpio_out_i),
    .gpio_oe_i    (gpio_oe_i),
    .periph_out_i (periph_out_i),
    .periph_oe_i  (periph_oe_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o)
  );

  assign func_code_o = code;

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_chk
    AST_PAD_GPIO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_code_o[p*3 +: 3] == 3'd0) |-> (pad_oe_o[p] == gpio_oe_i[p])); // R7
    AST_PAD_PERIPH_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (func_code_o[p*3 +: 3] == 3'd1) |-> (pad_oe_o[p] == periph_oe_i[p])); // R8
  end
endmodule

// File: tb/pin_func_sel_tb.sv
module pin_func_sel_tb_top;
  localparam int NP = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [NP-1:0] req_wdata = '0;
  logic [NP-1:0] rsp_rdata;
  logic [NP-1:0] gpio_out = '0, gpio_oe = '0;
  logic [5*NP-1:0] periph_out = '0, periph_oe = '0;
  logic [NP-1:0] pad_out, pad_oe, pull_sel;
  logic [3*NP-1:0] func_code;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pin_func_sel #(.NUM_PINS(NP)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .rsp_rdata_o(rsp_rdata),
    .gpio_out_i(gpio_out), .gpio_oe_i(gpio_oe),
    .periph_out_i(periph_out), .periph_oe_i(periph_oe),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe),
    .pull_sel_o(pull_sel), .func_code_o(func_code)
  );

  // reference model
  logic [NP-1:0] m_sel [5];
  logic [NP-1:0] m_pull;
  logic [NP-1:0] m_rdata;
  bit            m_undef_rd;

  function automatic int addr_idx(input logic [7:0] a);
    case (a)
      8'h14: return 0;
      8'h8C: return 1;
      8'h94: return 2;
      8'h9C: return 3;
      8'hA4: return 4;
      8'hAC: return 5;
      default: return -1;
    endcase
  endfunction

  function automatic int exp_code(input int p);
    for (int k = 0; k < 5; k++)
      if (m_sel[k][p]) return k + 1;
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 5; k++) m_sel[k] <= '0;
      m_pull <= '0;
      m_rdata <= '0;
      m_undef_rd <= 1'b0;
    end else begin
      int ix;
      ix = addr_idx(req_addr);
      if (req_valid && req_write) begin
        if (ix >= 0 && ix < 5) m_sel[ix] <= req_wdata;
        else if (ix == 5)      m_pull <= req_wdata;
      end
      m_undef_rd <= req_valid && !req_write && ix < 0;
      if (req_valid && !req_write)
        m_rdata <= (ix < 0) ? '0 : (ix == 5) ? m_pull : m_sel[ix];
      else
        m_rdata <= '0;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      chk(rsp_rdata == m_rdata, m_undef_rd ? "R3 undefined read" : "R2 read data", rsp_rdata, m_rdata);
      chk(pull_sel == m_pull, "R9 pull select", pull_sel, m_pull);
      for (int p = 0; p < NP; p++) begin
        int c;
        logic eo, ee;
        c = exp_code(p);
        chk(func_code[p*3 +: 3] == 3'(c), c == 0 ? "R5 R6 gpio fallback" : "R4 R6 priority",
            32'(func_code[p*3 +: 3]), 32'(c));
        eo = (c == 0) ? gpio_out[p] : periph_out[(c-1)*NP + p];
        ee = (c == 0) ? gpio_oe[p]  : periph_oe[(c-1)*NP + p];
        chk(pad_out[p] == eo && pad_oe[p] == ee, c == 0 ? "R7 gpio pad" : "R8 periph pad",
            {30'd0, pad_out[p], pad_oe[p]}, {30'd0, eo, ee});
      end
    end
  end

  task automatic shake_inputs();
    gpio_out = $urandom; gpio_oe = $urandom;
    for (int k = 0; k < 5; k++) begin
      periph_out[k*NP +: NP] = $urandom;
      periph_oe[k*NP +: NP]  = $urandom;
    end
  endtask

  task automatic bus(input bit v, input bit w, input logic [7:0] a, input logic [NP-1:0] d);
    @(posedge clk); #5;
    req_valid = v; req_write = w; req_addr = a; req_wdata = d;
    shake_inputs();
  endtask

  task automatic wr(input logic [7:0] a, input logic [NP-1:0] d); bus(1, 1, a, d); endtask
  task automatic rd(input logic [7:0] a); bus(1, 0, a, '0); endtask
  task automatic idle(); bus(0, 0, '0, '0); endtask

  localparam logic [7:0] ADDRS [6] = '{8'h14, 8'h8C, 8'h94, 8'h9C, 8'hA4, 8'hAC};

  initial begin
    #1 rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk(func_code == '0, "R1 reset codes", func_code[31:0], 32'd0);
    chk(rsp_rdata == '0 && pull_sel == '0, "R1 reset regs", rsp_rdata | pull_sel, 32'd0);
    for (int k = 0; k < 6; k++) rd(ADDRS[k]);
    idle();
    // each register alone, then read back (R2)
    for (int k = 0; k < 6; k++) wr(ADDRS[k], 32'h1 << (k * 5) | 32'h8000_0000 >> k);
    for (int k = 0; k < 6; k++) begin rd(ADDRS[k]); idle(); end
    // undefined offsets (R3)
    rd(8'h00); rd(8'h18); rd(8'hFF);
    wr(8'h10, 32'hFFFF_FFFF); wr(8'h90, 32'hFFFF_FFFF); wr(8'hA8, 32'hFFFF_FFFF);
    for (int k = 0; k < 6; k++) rd(ADDRS[k]);
    idle();
    // overlap: all set, remove from the top of priority (R4)
    for (int k = 0; k < 5; k++) wr(ADDRS[k], 32'hFFFF_FFFF);
    repeat (3) idle();
    for (int k = 0; k < 5; k++) begin
      wr(ADDRS[k], 32'h0);
      repeat (3) idle();
    end
    // random phase
    for (int i = 0; i < 1500; i++) begin
      int sel;
      sel = $urandom_range(0, 7);
      if (sel < 6) bus($urandom_range(0, 3) != 0, $urandom_range(0, 1) == 1, ADDRS[sel], $urandom);
      else         bus(1, $urandom_range(0, 1) == 1, 8'($urandom), $urandom);
    end
    // back to GPIO everywhere (R5)
    for (int k = 0; k < 5; k++) wr(ADDRS[k], '0);
    repeat (4) idle();
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1'b1;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule